// File: doc/BRIEF.md
# Predicated Signed Vector Compare Unit

This block compares two packed vectors of signed integers lane by lane, under the control of a governing mask. Each active lane is tested for "first operand less than or equal to second operand". The answer for that lane goes into a destination mask. The same block can instead run a greater-or-equal test. It does this by swapping the two operands inside the block, so both tests share one comparator. Element width is chosen per operation with a 2-bit code, from 8 to 64 bits.

Both the governing mask and the destination mask carry one bit per byte of the vector. For an element, only the bit at its lowest byte counts. The other bits of the element are cleared in the result.

From the result mask and the governing mask, the block derives four condition flags:
- N: the first active lane is true.
- Z: no active lane is true.
- C: the last active lane is not true.
- V: always zero.

Inputs are captured on a valid strobe. The result mask and flags appear one cycle later, with a one-cycle done pulse.

Top module: `vcmp_pred_top`

## Requirements
- R1: Each active lane compares its elements as two's-complement signed numbers. The result bit is 1 when A <= B in le mode (ge_mode=0), and when A >= B in ge mode (ge_mode=1).
- R2: A ge-mode compare of (A,B) gives exactly the same mask and flags as a le-mode compare of (B,A).
- R3: A lane whose governing bit (the bit at the element's lowest byte) is 0 yields 0, whatever the operand values.
- R4: The size code sets the element width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. Element k occupies bits [k*W +: W].
- R5: Result mask bits that do not sit at an element's lowest byte are always 0.
- R6: flags[3] (N) is 1 exactly when the lowest-index active lane's result is 1.
- R7: flags[2] (Z) is 1 exactly when no active lane's result is 1.
- R8: flags[1] (C) is 1 exactly when the highest-index active lane's result is 0. With no active lane, N=0, Z=1, C=1.
- R9: flags[0] (V) is always 0.
- R10: Mask, flags and done are updated exactly one cycle after the cycle in which valid is high. done is a single-cycle pulse, and outputs hold their values otherwise. Synchronous reset clears mask and done, and sets the flags to 4'b0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation strobe, inputs captured |
| ge_mode | input | 1 | 0 = A<=B, 1 = A>=B |
| size | input | 2 | Element width code |
| gov | input | VW/8 | Governing mask, one bit per byte |
| opa | input | VW | First operand vector |
| opb | input | VW | Second operand vector |
| res_mask | output | VW/8 | Destination mask |
| flags | output | 4 | {N,Z,C,V} |
| done | output | 1 | Result valid pulse |

## Verification
Each size code is run with random operands against a bench-side reference, which checks signed lane splitting and mask clearing together. Operands that differ only in the sign bit, or that sit at the most negative or most positive value, tell signed ordering apart from unsigned ordering. Equal operands tell <= apart from <.

Other patterns target the flags and the masking:
- An all-inactive mask pins the empty-set flag values.
- A single-active-lane mask makes first and last the same lane.
- Masks whose first and last active lanes disagree separate N from C.
- Setting the unused mask bits checks that they are ignored.
- Swapped ge compares are checked against the le results.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esz_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam nzcv_t NZCV_EMPTY = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
endpackage

// File: rtl/vcmp_lane_cmp.sv
// Per-byte-lane signed compare slices. The compare for each element size
// is built from chunk results: each 8-bit chunk reports less-than and
// equal, and wider elements combine chunks from the top down.
module vcmp_lane_cmp #(
  parameter int VW = 128,
  localparam int NB = VW / 8
) (
  input  logic [VW-1:0] x,
  input  logic [VW-1:0] y,
  input  logic [1:0]    size,
  output logic [NB-1:0] le_at_byte
);
  // Per byte: unsigned less-than, signed less-than (top byte of an element), equal
  logic [NB-1:0] ult, slt, eqb;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign ult[b] = x[b*8 +: 8] < y[b*8 +: 8];
    assign slt[b] = $signed(x[b*8 +: 8]) < $signed(y[b*8 +: 8]);
    assign eqb[b] = x[b*8 +: 8] == y[b*8 +: 8];
  end

  // Combine over element of 2^L bytes. lt_L[b] valid at element-base b.
  localparam int NL = 4;
  logic [NB-1:0] lt_l [NL];
  logic [NB-1:0] eq_l [NL];

  // L=0: one byte; signed compare.
  assign lt_l[0] = slt;
  assign eq_l[0] = eqb;

  // Build higher levels: upper half signed, lower half unsigned.
  logic [NB-1:0] ltu_l [NL];  // unsigned less-than at level
  assign ltu_l[0] = ult;

  for (genvar l = 1; l < NL; l++) begin : g_lvl
    localparam int HB = 1 << (l - 1);
    for (genvar b = 0; b < NB; b++) begin : g_b
      if ((b % (2 * HB) == 0) && (b + 2 * HB <= NB)) begin : g_base
        assign lt_l[l][b]  = lt_l[l-1][b+HB] | (eq_l[l-1][b+HB] & ltu_l[l-1][b]);
        assign ltu_l[l][b] = ltu_l[l-1][b+HB] | (eq_l[l-1][b+HB] & ltu_l[l-1][b]);
        assign eq_l[l][b]  = eq_l[l-1][b+HB] & eq_l[l-1][b];
      end else begin : g_none
        assign lt_l[l][b]  = 1'b0;
        assign ltu_l[l][b] = 1'b0;
        assign eq_l[l][b]  = 1'b0;
      end
    end
  end

  always_comb begin
    le_at_byte = '0;
    for (int b = 0; b < NB; b++) begin
      unique case (size)
        2'b00: le_at_byte[b] = lt_l[0][b] | eq_l[0][b];
        2'b01: if (b % 2 == 0) le_at_byte[b] = lt_l[1][b] | eq_l[1][b];
        2'b10: if (b % 4 == 0) le_at_byte[b] = lt_l[2][b] | eq_l[2][b];
        default: if (b % 8 == 0) le_at_byte[b] = lt_l[3][b] | eq_l[3][b];
      endcase
    end
  end
endmodule

// File: rtl/vcmp_flag_gen.sv
// Derives N/Z/C/V from the result and effective active mask.
module vcmp_flag_gen
  import vcmp_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [NB-1:0] act,
  input  logic [NB-1:0] res,
  output nzcv_t         fl
);
  // Lowest active isolated via two's complement; highest via reversed scan.
  logic [NB-1:0] first_oh;
  logic [NB-1:0] last_oh;
  logic [NB-1:0] act_rev, last_rev;

  assign first_oh = act & (~act + 1'b1);

  for (genvar i = 0; i < NB; i++) begin : g_rev
    assign act_rev[i] = act[NB-1-i];
    assign last_oh[i] = last_rev[NB-1-i];
  end
  assign last_rev = act_rev & (~act_rev + 1'b1);

  always_comb begin
    fl.n = |(first_oh & res);
    fl.z = ~|(act & res);
    fl.c = ~|(last_oh & res);
    fl.v = 1'b0;
  end
endmodule

// File: rtl/vcmp_pred_top.sv
module vcmp_pred_top
  import vcmp_pkg::*;
#(
  parameter int VW = 128,
  localparam int NB = VW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          ge_mode,
  input  logic [1:0]    size,
  input  logic [NB-1:0] gov,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  output logic [NB-1:0] res_mask,
  output logic [3:0]    flags,
  output logic          done
);
  logic [VW-1:0] x, y;
  logic [NB-1:0] le_b, base_m, act, res_c;
  nzcv_t fl_c, fl_q;

  // GE(a,b) == LE(b,a)
  assign x = ge_mode ? opb : opa;
  assign y = ge_mode ? opa : opb;

  vcmp_lane_cmp #(.VW(VW)) u_cmp (
    .x(x), .y(y), .size(size), .le_at_byte(le_b)
  );

  always_comb begin
    base_m = '0;
    for (int b = 0; b < NB; b++) begin
      unique case (size)
        2'b00: base_m[b] = 1'b1;
        2'b01: base_m[b] = (b % 2 == 0);
        2'b10: base_m[b] = (b % 4 == 0);
        default: base_m[b] = (b % 8 == 0);
      endcase
    end
  end

  assign act   = gov & base_m;
  assign res_c = le_b & act;

  vcmp_flag_gen #(.NB(NB)) u_flg (
    .act(act), .res(res_c), .fl(fl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_mask <= '0;
      fl_q     <= NZCV_EMPTY;
      done     <= 1'b0;
    end else begin
      done <= valid;
      if (valid) begin
        res_mask <= res_c;
        fl_q     <= fl_c;
      end
    end
  end

  assign flags = fl_q;
endmodule

// File: rtl/vcmp_pred_chk.sv
module vcmp_pred_chk #(
  parameter int NB = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          valid,
  input logic [1:0]    size,
  input logic [NB-1:0] gov,
  input logic [NB-1:0] res_mask,
  input logic [3:0]    flags,
  input logic          done
);
  logic [NB-1:0] base_q;
  logic [NB-1:0] gov_q;
  always_ff @(posedge clk) begin
    gov_q <= gov;
    for (int b = 0; b < NB; b++)
      base_q[b] <= (b % (1 << size)) == 0;
  end

  AST_V_ZERO: assert property (@(posedge clk) disable iff (rst) flags[0] == 1'b0); // R9
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst) valid |=> done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) !valid |=> !done); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !valid |=> $stable(res_mask) && $stable(flags)); // R10
  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst) valid |=> (res_mask & ~gov_q) == '0); // R3
  AST_NONBASE_ZERO: assert property (@(posedge clk) disable iff (rst) valid |=> (res_mask & ~base_q) == '0); // R5
  AST_Z_MATCH: assert property (@(posedge clk) disable iff (rst) done |-> flags[2] == (res_mask == '0)); // R7
  AST_N_IMPLIES_NZ: assert property (@(posedge clk) disable iff (rst) done && flags[3] |-> !flags[2]); // R6
endmodule

bind vcmp_pred_top vcmp_pred_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .size(size), .gov(gov),
  .res_mask(res_mask), .flags(flags), .done(done)
);

// File: tb/vcmp_pred_top_tb.sv
module vcmp_pred_top_tb;
  localparam int VW = 128;
  localparam int NB = VW / 8;

  logic clk = 0, rst = 1, valid = 0, ge_mode = 0;
  logic [1:0] size = 0;
  logic [NB-1:0] gov = 0;
  logic [VW-1:0] opa = 0, opb = 0;
  logic [NB-1:0] res_mask;
  logic [3:0] flags;
  logic done;
  int checks = 0, errors = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  vcmp_pred_top #(.VW(VW)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic ge, input logic [1:0] sz, input logic [NB-1:0] g,
                                input logic [VW-1:0] a, input logic [VW-1:0] b,
                                output logic [NB-1:0] m, output logic [3:0] f);
    int w = 8 << sz, eb = 1 << sz;
    int first = -1, last = -1;
    m = '0;
    for (int k = 0; k < NB / eb; k++) begin
      logic signed [64:0] ea = '0, ebv = '0;
      for (int i = 0; i < w; i++) begin
        ea[i] = a[k*w+i];
        ebv[i] = b[k*w+i];
      end
      for (int i = w; i < 65; i++) begin
        ea[i] = a[k*w+w-1];
        ebv[i] = b[k*w+w-1];
      end
      if (g[k*eb]) begin
        if (first < 0) first = k*eb;
        last = k*eb;
        m[k*eb] = ge ? (ea >= ebv) : (ea <= ebv);
      end
    end
    f[3] = (first >= 0) && m[first];
    f[2] = (m == '0);
    f[1] = (last < 0) || !m[last];
    f[0] = 1'b0;
  endfunction

  // Apply one op, check mask/flags/done next cycle.
  task automatic run(input string req, input logic ge, input logic [1:0] sz,
                     input logic [NB-1:0] g, input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [NB-1:0] em; logic [3:0] ef;
    model(ge, sz, g, a, b, em, ef);
    @(negedge clk);
    valid = 1; ge_mode = ge; size = sz; gov = g; opa = a; opb = b;
    @(negedge clk);
    valid = 0;
    chk({req, " R10 done"}, done, 1);
    chk({req, " mask"}, res_mask, em);
    chk({req, " flags"}, flags, ef);
    @(negedge clk);
    chk("R10 pulse", done, 0);
    chk("R10 hold", res_mask, em);
  endtask

  function automatic logic [VW-1:0] fill(input logic [1:0] sz, input logic [63:0] v);
    int w = 8 << sz;
    logic [VW-1:0] r = '0;
    for (int k = 0; k < VW / w; k++)
      for (int i = 0; i < w; i++) r[k*w+i] = v[i];
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset mask", res_mask, 0);
    chk("R10 reset flags", flags, 4'b0110);
    chk("R10 reset done", done, 0);
  endtask

  task automatic t_random();
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 20; n++) begin
        logic [VW-1:0] a = rnd(), b = rnd();
        logic [NB-1:0] g = NB'($urandom);
        if (n % 4 == 0) b = a;  // equality lanes
        run("R1 R4 R5 random", 0, 2'(s), g, a, b);
        run("R1 ge random", 1, 2'(s), g, a, b);
      end
  endtask

  task automatic t_swap();
    for (int s = 0; s < 4; s++) begin
      logic [VW-1:0] a = rnd(), b = rnd();
      logic [NB-1:0] m1, m2; logic [3:0] f1, f2;
      run("R2 ge", 1, 2'(s), '1, a, b); m1 = res_mask; f1 = flags;
      run("R2 le swapped", 0, 2'(s), '1, b, a); m2 = res_mask; f2 = flags;
      chk("R2 mask equal", m1, m2);
      chk("R2 flags equal", f1, f2);
    end
  endtask

  task automatic t_inactive();
    for (int s = 0; s < 4; s++) begin
      run("R3 R8 all inactive", 0, 2'(s), '0, '0, '0);
      chk("R8 empty flags", flags, 4'b0110);
    end
  endtask

  task automatic t_single();
    for (int s = 0; s < 4; s++) begin
      int eb = 1 << s;
      for (int k = 0; k < NB / eb; k += 1) begin
        logic [NB-1:0] g = '0;
        g[k*eb] = 1;
        run("R6 R8 single lane", 0, 2'(s), g, rnd(), rnd());
      end
    end
  endtask

  task automatic t_bounds();
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      logic [63:0] mn = 64'd1 << (w - 1);
      logic [63:0] mx = mn - 1;
      run("R1 min<=max", 0, 2'(s), '1, fill(2'(s), mn), fill(2'(s), mx));
      chk("R6 N min<=max", flags[3], 1);
      run("R1 max<=min", 0, 2'(s), '1, fill(2'(s), mx), fill(2'(s), mn));
      chk("R7 Z max<=min", flags[2], 1);
      run("R1 -1<=0", 0, 2'(s), '1, fill(2'(s), '1), '0);
      run("R5 nonbase gov bits", 0, 2'(s), '1, '0, '0);
      chk("R9 V zero", flags[0], 0);
    end
  endtask

  task automatic t_first_last();
    // lane0: 0<=1 true; lane15: 1<=0 false -> N=1, C=1
    logic [VW-1:0] a = '0, b = '0;
    b[7:0] = 1; a[127:120] = 1;
    run("R6 R8 first true last false", 0, 0, '1, a, b);
    chk("R6 N", flags[3], 1);
    chk("R8 C", flags[1], 1);
    run("R6 R8 first false last true", 0, 0, '1, b, a);
    chk("R6 N", flags[3], 0);
    chk("R8 C", flags[1], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_random();
    t_swap();
    t_inactive();
    t_single();
    t_bounds();
    t_first_last();
    fin = 1;
  end

  initial begin
    fork
      wait (fin);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule